// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fetch Unit

This unit sits on the memory side of a one-word-wide bus and answers four-word cache block reads. A requester presents a block address and a timing mode while the unit is idle. The unit drives the block's word address onto the bus for one cycle and counts out the array access latency. It then returns the four words of the block one per data beat, in ascending word offset, with a valid strobe and a last flag on the fourth beat.

The storage is four internal banks, and word offset k of every block lives in bank k. The timing mode picks one of three access models. In the interleaved model all four banks are read together, so the words arrive on four back-to-back cycles. In the open-row burst model one bank streams the block from a single open row, with a shorter column access between words. In the row-miss model every word pays a full row access. When the block finishes, the unit latches its total latency in cycles, so the miss penalty of each model can be read directly. A word-wide fill port loads the banks.

Top module: `blkfetch_unit`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, `busy`, `bus_addr_valid`, `rdata_valid` and `rdata_last` are 0 and `done_cycles` is 0.
- R2: A request (`req_valid` high) is taken only on a clock edge where `busy` is 0. A request presented while busy has no effect: it starts no address cycle and adds no beats.
- R3: On the cycle after a request is taken, `bus_addr_valid` is high for exactly one cycle, and `bus_addr` equals the block address followed by two zero bits. This is the block's first word address.
- R4: Mode 0 (interleaved) returns the four beats on cycles 17, 18, 19 and 20. The address cycle counts as cycle 1.
- R5: Mode 1 (open-row burst) returns the beats on cycles 17, 22, 27 and 32: a 15-cycle row access, then a 5-cycle column access per further word.
- R6: Modes 2 and 3 (row miss) return the beats on cycles 17, 32, 47 and 62, with each word paying a 15-cycle row access.
- R7: Beat k (k = 0..3) carries the stored word at word address {block, k}. `rdata_last` is high on beat 3 only.
- R8: From the cycle after the last beat, `done_cycles` holds the block's total latency: 20, 32 or 62 for the mode used. It keeps that value until the next block completes.
- R9: `busy` is high from the address cycle through the last beat, and low on the cycle after the last beat.
- R10: A fill write (`wr_en` high at a clock edge) stores `wr_data` at word address `wr_addr`. Bits [1:0] of that address select the bank, and a later fetch of that block returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Block read request |
| req_mode | input | 2 | Timing mode: 0 interleaved, 1 open-row burst, 2 or 3 row miss |
| req_blk | input | BLK_AW (6) | Block address |
| wr_en | input | 1 | Fill write enable |
| wr_addr | input | BLK_AW+2 (8) | Fill word address; low two bits select the bank |
| wr_data | input | DATA_W (32) | Fill data |
| busy | output | 1 | A block is in progress |
| bus_addr_valid | output | 1 | Address cycle on the bus |
| bus_addr | output | BLK_AW+2 (8) | Word address of the block's first word |
| rdata_valid | output | 1 | Data beat strobe |
| rdata | output | DATA_W (32) | Returned word |
| rdata_last | output | 1 | Marks the fourth beat |
| done_cycles | output | 8 | Total latency of the last completed block |

## Verification
The assertions assume that `req_mode` and `req_blk` are valid whenever `req_valid` is high. They also assume that fill writes never target the block being returned. The timing checks count beats from the address cycle, so they rely on each accepted request being one whole transaction that is not disturbed by later requests. The stimulus issues fill writes only while the unit is idle, and it holds all request fields steady for the single cycle in which a request is offered. The one deliberate request made during a transfer probes that it is ignored.

// File: rtl/blkfetch_pkg.sv
// Shared encodings and timing helpers for the block fetch unit.
// Assumes a 2-bit mode field; mode 3 is treated as the row-miss model.
package blkfetch_pkg;

    localparam logic [1:0] MODE_ILV   = 2'd0;
    localparam logic [1:0] MODE_BURST = 2'd1;
    localparam logic [1:0] MODE_MISS  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_XFER   = 2'd3
    } fetch_state_t;

    // Cycles between consecutive data beats for a given mode.
    function automatic int unsigned beat_gap(logic [1:0] mode, int unsigned t_row,
                                             int unsigned t_col);
        case (mode)
            MODE_ILV:   return 1;
            MODE_BURST: return t_col;
            default:    return t_row;
        endcase
    endfunction

endpackage

// File: rtl/blkfetch_bank.sv
// One storage bank: synchronous write, combinational read.
// Assumes the contents are loaded through the write port before they are read.
module blkfetch_bank #(
    parameter int DATA_W  = 32,
    parameter int DEPTH_AW = 6
) (
    input  logic                clk,
    input  logic                we,
    input  logic [DEPTH_AW-1:0] waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DEPTH_AW-1:0] raddr,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << DEPTH_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/blkfetch_seq.sv
// Latency sequencer: takes a request when idle, runs the address cycle,
// the first row access, then one beat per mode-dependent gap, and latches
// the total cycle count of the block. Assumes WORDS >= 2.
module blkfetch_seq
    import blkfetch_pkg::*;
#(
    parameter int BLK_AW = 6,
    parameter int WORDS  = 4,
    parameter int T_ROW  = 15,
    parameter int T_COL  = 5,
    parameter int CYC_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_mode,
    input  logic [BLK_AW-1:0]        req_blk,
    output logic                     busy,
    output logic                     addr_valid,
    output logic [BLK_AW-1:0]        blk_q,
    output logic [$clog2(WORDS)-1:0] beat,
    output logic                     beat_valid,
    output logic                     beat_last,
    output logic [CYC_W-1:0]         done_cycles
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int CNT_W = $clog2(T_ROW + 1);

    fetch_state_t   state;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       mode_q;
    logic [CYC_W-1:0] cyc;
    logic [CNT_W-1:0] gap_m1;

    // Reload value for the wait between beats.
    always_comb begin
        gap_m1 = CNT_W'(beat_gap(mode_q, T_ROW, T_COL) - 1);
    end

    // Phase sequencing, beat counting and latency capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            beat        <= '0;
            mode_q      <= MODE_ILV;
            blk_q       <= '0;
            cyc         <= '0;
            done_cycles <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        mode_q <= req_mode;
                        blk_q  <= req_blk;
                        cyc    <= CYC_W'(1);
                        beat   <= '0;
                        state  <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    cyc   <= cyc + CYC_W'(1);
                    cnt   <= CNT_W'(T_ROW - 1);
                    state <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    cyc <= cyc + CYC_W'(1);
                    if (cnt == '0) begin
                        state <= ST_XFER;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_XFER: begin
                    cyc <= cyc + CYC_W'(1);
                    if (cnt == '0) begin
                        if (beat == OFF_W'(WORDS - 1)) begin
                            done_cycles <= cyc;
                            beat        <= '0;
                            state       <= ST_IDLE;
                        end else begin
                            beat <= beat + OFF_W'(1);
                            cnt  <= gap_m1;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign addr_valid = (state == ST_ADDR);
    assign beat_valid = (state == ST_XFER) && (cnt == '0);
    assign beat_last  = beat_valid && (beat == OFF_W'(WORDS - 1));

endmodule

// File: rtl/blkfetch_unit.sv
// Top of the block fetch unit: four banks (word offset k in bank k),
// a fill port, the latency sequencer and the beat data select.
// Assumes fill writes do not target a block that is being returned.
module blkfetch_unit #(
    parameter int BLK_AW = 6,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int T_ROW  = 15,
    parameter int T_COL  = 5,
    parameter int CYC_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [1:0]                      req_mode,
    input  logic [BLK_AW-1:0]               req_blk,
    input  logic                            wr_en,
    input  logic [BLK_AW+$clog2(WORDS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic                            busy,
    output logic                            bus_addr_valid,
    output logic [BLK_AW+$clog2(WORDS)-1:0] bus_addr,
    output logic                            rdata_valid,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rdata_last,
    output logic [CYC_W-1:0]                done_cycles
);
    localparam int OFF_W = $clog2(WORDS);

    logic [BLK_AW-1:0] blk_q;
    logic [OFF_W-1:0]  beat;
    logic [DATA_W-1:0] bank_rd [WORDS];

    blkfetch_seq #(
        .BLK_AW(BLK_AW), .WORDS(WORDS), .T_ROW(T_ROW), .T_COL(T_COL), .CYC_W(CYC_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .req_blk     (req_blk),
        .busy        (busy),
        .addr_valid  (bus_addr_valid),
        .blk_q       (blk_q),
        .beat        (beat),
        .beat_valid  (rdata_valid),
        .beat_last   (rdata_last),
        .done_cycles (done_cycles)
    );

    for (genvar b = 0; b < WORDS; b++) begin : g_bank
        blkfetch_bank #(.DATA_W(DATA_W), .DEPTH_AW(BLK_AW)) u_bank (
            .clk   (clk),
            .we    (wr_en && (wr_addr[OFF_W-1:0] == OFF_W'(b))),
            .waddr (wr_addr[BLK_AW+OFF_W-1:OFF_W]),
            .wdata (wr_data),
            .raddr (blk_q),
            .rdata (bank_rd[b])
        );
    end

    assign bus_addr = {blk_q, {OFF_W{1'b0}}};
    assign rdata    = bank_rd[beat];

endmodule

// File: rtl/blkfetch_unit_chk.sv
// Protocol and timing checker for blkfetch_unit, attached by bind.
// Counts cycles from each address cycle and beats within a block.
module blkfetch_unit_chk
    import blkfetch_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int T_ROW = 15,
    parameter int T_COL = 5,
    parameter int CYC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_mode,
    input logic             busy,
    input logic             bus_addr_valid,
    input logic             rdata_valid,
    input logic             rdata_last,
    input logic [CYC_W-1:0] done_cycles
);
    logic [1:0] mode_cap;
    int         since_addr;
    int         beat_n;
    int         gap;

    assign gap = int'(beat_gap(mode_cap, T_ROW, T_COL));

    // Track mode, cycles since address and beats seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cap   <= MODE_ILV;
            since_addr <= 0;
            beat_n     <= 0;
        end else begin
            if (req_valid && !busy) mode_cap <= req_mode;
            if (bus_addr_valid) begin
                since_addr <= 1;
                beat_n     <= 0;
            end else begin
                if (since_addr < 1000) since_addr <= since_addr + 1;
                if (rdata_valid) beat_n <= beat_n + 1;
            end
        end
    end

    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !bus_addr_valid);
    p_addr_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_valid |=> !bus_addr_valid);
    p_beat_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (since_addr == T_ROW + 1 + beat_n * gap));
    p_last_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_last |-> (rdata_valid && beat_n == WORDS - 1));
    p_done_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_valid && rdata_last) |=> (int'(done_cycles) == 2 + T_ROW + (WORDS - 1) * gap));
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdata_valid && rdata_last) |=> $stable(done_cycles));
    p_busy_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_valid || rdata_valid) |-> busy);
    p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_valid && rdata_last) |=> !busy);

endmodule

bind blkfetch_unit blkfetch_unit_chk #(
    .WORDS(WORDS), .T_ROW(T_ROW), .T_COL(T_COL), .CYC_W(CYC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_mode       (req_mode),
    .busy           (busy),
    .bus_addr_valid (bus_addr_valid),
    .rdata_valid    (rdata_valid),
    .rdata_last     (rdata_last),
    .done_cycles    (done_cycles)
);

// File: tb/blkfetch_unit_test.sv
// Scoreboard bench: the fetch task queues the expected beats with their
// cycle numbers, and a monitor pops and compares them at each falling edge.
module blkfetch_unit_test;
    localparam int BLK_AW = 6;
    localparam int DATA_W = 32;
    localparam int AW     = BLK_AW + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_mode = 2'd0;
    logic [BLK_AW-1:0] req_blk = '0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              busy, bus_addr_valid, rdata_valid, rdata_last;
    logic [AW-1:0]     bus_addr;
    logic [DATA_W-1:0] rdata;
    logic [7:0]        done_cycles;

    typedef struct {
        int          cyc;
        logic [31:0] data;
        logic        last;
        string       rq;
    } beat_t;

    beat_t       sb[$];
    logic [31:0] model [256];
    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc_now = 0;
    int          last_done = 0;
    bit          finished = 1'b0;

    blkfetch_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_blk(req_blk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr),
        .rdata_valid(rdata_valid), .rdata(rdata), .rdata_last(rdata_last),
        .done_cycles(done_cycles)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc_now++;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Monitor: compare each beat against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rdata_valid && !finished) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "beat with nothing queued", 1, 0);
            end else begin
                beat_t e;
                e = sb.pop_front();
                check(cyc_now == e.cyc, e.rq, "beat cycle", cyc_now, e.cyc);
                check(rdata == e.data, "R7", "beat data", rdata, e.data);
                check(rdata_last == e.last, "R7", "last flag", rdata_last, e.last);
            end
        end
    end

    task automatic fill(input int a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        @(negedge clk);
        wr_en    = 1'b0;
        model[a] = d;
    endtask

    // Driver: issue one block request, queue expectations, wait for the end.
    task automatic fetch(input int blk, input logic [1:0] mode, input string rq,
                         input int exp_total, input bit poke);
        int base;
        int gap;
        req_valid = 1'b1;
        req_blk   = BLK_AW'(blk);
        req_mode  = mode;
        @(negedge clk);
        req_valid = 1'b0;
        base = cyc_now;
        check(bus_addr_valid == 1'b1, "R3", "address strobe", bus_addr_valid, 1);
        check(bus_addr == AW'(blk * 4), "R3", "bus address", bus_addr, blk * 4);
        check(busy == 1'b1, "R9", "busy in address cycle", busy, 1);
        check(int'(done_cycles) == last_done, "R8", "count held", done_cycles, last_done);
        gap = (mode == 2'd0) ? 1 : (mode == 2'd1) ? 5 : 15;
        for (int k = 0; k < 4; k++) begin
            beat_t e;
            e.cyc  = base + 16 + k * gap;
            e.data = model[blk * 4 + k];
            e.last = (k == 3);
            e.rq   = rq;
            sb.push_back(e);
        end
        @(negedge clk);
        check(bus_addr_valid == 1'b0, "R3", "strobe one cycle", bus_addr_valid, 0);
        if (poke) begin
            req_valid = 1'b1;
            req_blk   = BLK_AW'(blk ^ 1);
            req_mode  = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
            check(bus_addr_valid == 1'b0, "R2", "request while busy", bus_addr_valid, 0);
            check(busy == 1'b1, "R9", "busy during access", busy, 1);
        end
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R9", "idle after last beat", busy, 0);
        check(int'(done_cycles) == exp_total, "R8", "completion count", done_cycles, exp_total);
        last_done = exp_total;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && bus_addr_valid == 1'b0, "R1", "idle in reset", busy, 0);
        check(rdata_valid == 1'b0 && rdata_last == 1'b0, "R1", "no beat in reset", rdata_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_cycles == 8'd0, "R1", "count after reset", done_cycles, 0);
        check(busy == 1'b0, "R1", "idle after reset", busy, 0);
        for (int a = 0; a < 256; a++) begin
            fill(a, 32'h5A00_0000 ^ (a * 32'h0001_0203) ^ 32'(a << 3));
        end
        fetch(0, 2'd0, "R4", 20, 1'b0);
        fetch(5, 2'd1, "R5", 32, 1'b0);
        fetch(63, 2'd2, "R6", 62, 1'b1);
        fetch(17, 2'd3, "R6", 62, 1'b0);
        fill(17 * 4 + 2, 32'hDEAD_BEEF);          // R10: overwrite bank 2 of block 17
        fill(17 * 4 + 0, 32'h0BAD_F00D);          // R10: overwrite bank 0 of block 17
        fetch(17, 2'd0, "R10", 20, 1'b1);
        fetch(33, 2'd1, "R5", 32, 1'b0);
        fetch(42, 2'd0, "R4", 20, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule